// File: doc/BRIEF.md
# Host Bus Address Latch and Front-End Select Decoder

This block sits between a host processor's multiplexed address/data bus and a sensor readout subsystem. While the subsystem select is low, an address-latch-enable pulse captures two 4-bit address fields. The first field, taken from AD[9:6], is decoded into active-low chip selects for up to fifteen front-end arrays. The second field, taken from AD[15:12], serves the pulse-height processor and supplies the upper RAM address bits during host reads.

Each field latch is transparent while capture is enabled, so its output follows the bus directly. It holds the value sampled on the last clock edge of the capture window. A 4-bit steering mux sends the host page field to the RAM's upper address bits during a host read. At all other times the accumulation controller owns those bits. Front-end selects and the front-end bus enable are gated by a set-up mode bit. The host sets or clears that bit by writing AD[0] while the latched page field equals a configuration page.

Top module: `hbus_addr_decode`

## Requirements
- R1: While ale_i is high and sel_ni is low, the front-end code output and the page output follow AD[9:6] and AD[15:12] in the same cycle, with no clock delay.
- R2: When capture ends, both fields hold the value present on the last rising clock edge of the capture window, whatever ad_i does afterwards.
- R3: ale_i high while sel_ni is high captures nothing, and the previously held fields are unchanged.
- R4: pha_page_o presents the page field (AD[15:12]) at all times, whether it is live or held.
- R5: With set-up mode on and sel_ni low, front-end code k below NUM_FE drives fe_cs_no[k] low and every other select high. At most one select is low at any time.
- R6: Code 4'hF, and any code at or above NUM_FE, drives no select low.
- R7: With sel_ni high, every front-end select is high.
- R8: With set-up mode off, every front-end select is high and fe_bus_en_o is low. With set-up mode on, fe_bus_en_o equals the inverse of sel_ni.
- R9: On a rising clock edge with sel_ni low, wr_ni low and a held page field equal to CFG_PAGE (default 4'hF), set-up mode takes the value of ad_i[0]. A write under any other page leaves set-up mode unchanged.
- R10: ram_hi_addr_o equals the page field when both sel_ni and rd_ni are low, and equals acc_addr_i otherwise.
- R11: After reset, both held fields are 4'hF, set-up mode is off, and all selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ale_i | input | 1 | Address latch enable, active high |
| sel_ni | input | 1 | Subsystem select, active low |
| rd_ni | input | 1 | Host read strobe, active low |
| wr_ni | input | 1 | Host write strobe, active low |
| ad_i | input | 16 | Multiplexed address/data bus |
| acc_addr_i | input | 4 | Upper RAM address from the accumulation controller |
| fe_cs_no | output | 15 | Front-end array chip selects, active low |
| fe_bus_en_o | output | 1 | Front-end bus access enable |
| pha_page_o | output | 4 | Page field for the pulse-height processor |
| ram_hi_addr_o | output | 4 | Steered upper RAM address bits |

## Verification
The bench builds the default configuration, with fifteen selects. That exercises every mapped code and the reserved all-ones code. A second instance with NUM_FE set to 6 shares the same stimulus, which brings the unmapped codes 6 through 14 within reach: they must leave every select high, as code 4'hF does. Set-up mode is written on and off through the configuration page, and one write is aimed at a different page to show that it is ignored.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int unsigned AD_W     = 16;
  localparam int unsigned FIELD_W  = 4;
  localparam int unsigned FE_LSB   = 6;
  localparam int unsigned PAGE_LSB = 12;
  typedef logic [FIELD_W-1:0] field_t;
endpackage

// File: rtl/hbus_field_latch.sv
module hbus_field_latch #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] field_i,
  output logic [W-1:0] field_o
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    held_q <= '1;
    else if (cap_i) held_q <= field_i;
  end

  // transparent during capture, held otherwise
  assign field_o = cap_i ? field_i : held_q;

  assert_hold_on_close_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cap_i) |-> field_o == $past(field_i));
  assert_no_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i ##1 !cap_i |-> $stable(field_o));
endmodule

// File: rtl/hbus_cs_decoder.sv
module hbus_cs_decoder #(
  parameter int unsigned W      = 4,
  parameter int unsigned NUM_FE = 15
) (
  input  logic [W-1:0]      code_i,
  input  logic              en_i,
  output logic [NUM_FE-1:0] cs_no
);
  localparam int unsigned NUM_CODES = 1 << W;
  localparam int unsigned FE_LIM = (NUM_FE < NUM_CODES) ? NUM_FE : NUM_CODES - 1;

  for (genvar g = 0; g < NUM_FE; g++) begin : g_cs
    if (g < FE_LIM) begin : g_live
      assign cs_no[g] = ~(en_i && (code_i == W'(g)));
    end else begin : g_dead
      assign cs_no[g] = 1'b1;
    end
  end
endmodule

// File: rtl/hbus_setup_gate.sv
module hbus_setup_gate #(
  parameter int unsigned W        = 4,
  parameter logic [W-1:0] CFG_PAGE = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_ni,
  input  logic         wr_ni,
  input  logic [W-1:0] page_i,
  input  logic         data_i,
  output logic         setup_o,
  output logic         bus_en_o
);
  logic setup_q;
  logic cfg_wr;

  assign cfg_wr = !sel_ni && !wr_ni && (page_i == CFG_PAGE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     setup_q <= 1'b0;
    else if (cfg_wr) setup_q <= data_i;
  end

  assign setup_o  = setup_q;
  assign bus_en_o = setup_q && !sel_ni;

  assert_cfg_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ni && !wr_ni && page_i == CFG_PAGE) |=> setup_o == $past(data_i));
  assert_other_page_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_i != CFG_PAGE) |=> $stable(setup_o));
endmodule

// File: rtl/hbus_ram_steer.sv
module hbus_ram_steer #(
  parameter int unsigned W = 4
) (
  input  logic         sel_ni,
  input  logic         rd_ni,
  input  logic [W-1:0] host_i,
  input  logic [W-1:0] acc_i,
  output logic [W-1:0] addr_o
);
  always_comb begin
    if (!sel_ni && !rd_ni) addr_o = host_i;
    else                   addr_o = acc_i;
  end
endmodule

// File: rtl/hbus_addr_decode.sv
module hbus_addr_decode
  import hbus_pkg::*;
#(
  parameter int unsigned NUM_FE        = 15,
  parameter logic [FIELD_W-1:0] CFG_PAGE = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ale_i,
  input  logic               sel_ni,
  input  logic               rd_ni,
  input  logic               wr_ni,
  input  logic [AD_W-1:0]    ad_i,
  input  logic [FIELD_W-1:0] acc_addr_i,
  output logic [NUM_FE-1:0]  fe_cs_no,
  output logic               fe_bus_en_o,
  output logic [FIELD_W-1:0] pha_page_o,
  output logic [FIELD_W-1:0] ram_hi_addr_o
);
  field_t fe_code;
  field_t page;
  logic   cap;
  logic   setup;
  logic   unused_ad;

  assign cap       = ale_i && !sel_ni;
  assign unused_ad = ^ad_i;

  hbus_field_latch #(.W(FIELD_W)) u_fe_lat (
    .clk_i, .rst_ni, .cap_i(cap),
    .field_i(ad_i[FE_LSB +: FIELD_W]), .field_o(fe_code)
  );

  hbus_field_latch #(.W(FIELD_W)) u_page_lat (
    .clk_i, .rst_ni, .cap_i(cap),
    .field_i(ad_i[PAGE_LSB +: FIELD_W]), .field_o(page)
  );

  hbus_setup_gate #(.W(FIELD_W), .CFG_PAGE(CFG_PAGE)) u_gate (
    .clk_i, .rst_ni, .sel_ni, .wr_ni,
    .page_i(page), .data_i(ad_i[0]),
    .setup_o(setup), .bus_en_o(fe_bus_en_o)
  );

  hbus_cs_decoder #(.W(FIELD_W), .NUM_FE(NUM_FE)) u_dec (
    .code_i(fe_code), .en_i(fe_bus_en_o), .cs_no(fe_cs_no)
  );

  hbus_ram_steer #(.W(FIELD_W)) u_steer (
    .sel_ni, .rd_ni, .host_i(page), .acc_i(acc_addr_i), .addr_o(ram_hi_addr_o)
  );

  assign pha_page_o = page;

  assert_one_select_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~fe_cs_no));
  assert_reserved_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_code == '1) |-> &fe_cs_no);
  assert_deselected_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |-> &fe_cs_no);
  assert_setup_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !setup |-> (&fe_cs_no && !fe_bus_en_o));
  assert_acc_owner_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ni || rd_ni) |-> ram_hi_addr_o == acc_addr_i);
  assert_host_owner_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_ni && !rd_ni) |-> ram_hi_addr_o == pha_page_o);
endmodule

// File: tb/tb_hbus_addr_decode.sv
module tb_hbus_addr_decode;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ale = 1'b0, sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] ad = '0;
  logic [3:0]  acc = '0;
  logic [14:0] cs_n;
  logic [5:0]  cs_small_n;
  logic        bus_en, bus_en_small;
  logic [3:0]  page, page_small, ram, ram_small;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  hbus_addr_decode dut (
    .clk_i(clk), .rst_ni, .ale_i(ale), .sel_ni(sel_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .ad_i(ad), .acc_addr_i(acc), .fe_cs_no(cs_n), .fe_bus_en_o(bus_en),
    .pha_page_o(page), .ram_hi_addr_o(ram)
  );

  hbus_addr_decode #(.NUM_FE(6)) dut_small (
    .clk_i(clk), .rst_ni, .ale_i(ale), .sel_ni(sel_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .ad_i(ad), .acc_addr_i(acc), .fe_cs_no(cs_small_n), .fe_bus_en_o(bus_en_small),
    .pha_page_o(page_small), .ram_hi_addr_o(ram_small)
  );

  typedef struct packed {
    logic        ale, sel_n, rd_n;
    logic [15:0] ad;
    logic [3:0]  acc;
    logic [14:0] cs;
    logic [3:0]  pg, rm;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b1, 16'h20C0, 4'h5, 15'h7FF7, 4'h2, 4'h5},
    '{1'b0, 1'b0, 1'b0, 16'hFFFF, 4'h5, 15'h7FF7, 4'h2, 4'h2},
    '{1'b0, 1'b1, 1'b0, 16'h0000, 4'h9, 15'h7FFF, 4'h2, 4'h9},
    '{1'b1, 1'b1, 1'b1, 16'hA1C0, 4'h3, 15'h7FFF, 4'h2, 4'h3},
    '{1'b0, 1'b0, 1'b1, 16'h0000, 4'h3, 15'h7FF7, 4'h2, 4'h3},
    '{1'b1, 1'b0, 1'b0, 16'h7380, 4'h0, 15'h3FFF, 4'h7, 4'h7},
    '{1'b1, 1'b0, 1'b1, 16'h13C0, 4'hC, 15'h7FFF, 4'h1, 4'hC},
    '{1'b0, 1'b0, 1'b1, 16'h0000, 4'h0, 15'h7FFF, 4'h1, 4'h0},
    '{1'b1, 1'b0, 1'b1, 16'hB000, 4'h4, 15'h7FFE, 4'hB, 4'h4}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic a, logic s, logic r, logic w, logic [15:0] d, logic [3:0] c);
    @(negedge clk);
    ale = a; sel_n = s; rd_n = r; wr_n = w; ad = d; acc = c;
    #5;
  endtask

  // cfg page capture then data write of bit 0
  task automatic cfg_write(logic [15:0] addr, logic bit0);
    drive(1'b1, 1'b0, 1'b1, 1'b1, addr, acc);
    drive(1'b0, 1'b0, 1'b1, 1'b0, {15'h0, bit0}, acc);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 16'h0, acc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R11 reset state
    check("R11 page", 32'(page), 32'hF);
    check("R11 cs", 32'(cs_n), 32'h7FFF);
    check("R11 bus_en", 32'(bus_en), 32'h0);
    @(negedge clk) rst_ni = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0, 4'h6);
    check("R11 held page", 32'(page), 32'hF);
    check("R8 setup off bus_en", 32'(bus_en), 32'h0);

    // R9 enable set-up mode via config page
    cfg_write(16'hF000, 1'b1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0, 4'h0);
    check("R9 setup on", 32'(bus_en), 32'h1);
    check("R5 held code0", 32'(cs_n), 32'h7FFE);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].ale, VECS[i].sel_n, VECS[i].rd_n, 1'b1, VECS[i].ad, VECS[i].acc);
      check($sformatf("R1/R2/R5/R6/R7 cs vec%0d", i), 32'(cs_n), 32'(VECS[i].cs));
      check($sformatf("R4 page vec%0d", i), 32'(page), 32'(VECS[i].pg));
      check($sformatf("R10 ram vec%0d", i), 32'(ram), 32'(VECS[i].rm));
      check($sformatf("R8 bus_en vec%0d", i), 32'(bus_en), 32'(!VECS[i].sel_n));
    end

    // R3 capture with sel high leaves both fields
    drive(1'b1, 1'b1, 1'b1, 1'b1, 16'h5140, 4'h0);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0, 4'h0);
    check("R3 cs kept", 32'(cs_n), 32'h7FFE);
    check("R3 page kept", 32'(page), 32'hB);

    // R6 unmapped codes on the 6-select instance
    drive(1'b1, 1'b0, 1'b1, 1'b1, 16'h0180, 4'h0);
    check("R6 small code6", 32'(cs_small_n), 32'h3F);
    check("R5 large code6", 32'(cs_n), 32'h7FBF);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 16'h0140, 4'h0);
    check("R5 small code5", 32'(cs_small_n), 32'h1F);

    // R9 write under another page is ignored
    cfg_write(16'h3000, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0, 4'h0);
    check("R9 other page ignored", 32'(bus_en), 32'h1);

    // R8 clear set-up mode, selects gated off
    cfg_write(16'hF080, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 16'h0080, 4'h0);
    check("R8 cs gated", 32'(cs_n), 32'h7FFF);
    check("R8 bus_en off", 32'(bus_en), 32'h0);
    check("R8 small gated", 32'(cs_small_n), 32'h3F);

    // R11 async reset mid-run
    @(negedge clk) rst_ni = 1'b0;
    ale = 1'b0;
    #2;
    check("R11 re-reset page", 32'(page), 32'hF);
    @(negedge clk) rst_ni = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule